// File: doc/BRIEF.md
# Link Adaptor Host Register Interface

This block is the byte-wide register port that a host processor uses to exchange bytes with a serial link engine. The host reaches four registers through a chip select, a read/write strobe and a two-bit register select. Two of them are data registers, one for each direction, and two are status registers. On the link side, the block takes a strobe with each received byte. It emits a one-clock start strobe with each byte to send, and it takes a pulse when the far end has acknowledged the last byte sent.

Each direction has a status register. It pairs a hardware flag with an interrupt enable that the host controls. The receive flag marks that a byte is waiting. The transmit flag marks that the host may send the next byte. Each interrupt output is the live AND of its flag and its enable, so the host can mask and unmask an interrupt without losing the event behind it.

Top module: `link_host_regs`

## Requirements
- R1: After reset, data-present is 0, output-ready is 1, both interrupt enables are 0, both interrupt outputs are 0 and tx_start_o is 0.
- R2: A host access occurs in any cycle with cs_i high. rnw_i=1 selects a read and rnw_i=0 a write. sel_i picks the register: 0 = input data, 1 = output data, 2 = input status, 3 = output status. rdata_o shows the selected register in the same cycle during a read and is 0 otherwise. In a status register, bit 0 is the flag, bit 1 is the interrupt enable, and bits 7:2 are 0.
- R3: A cycle with rx_valid_i high loads rx_data_i into the input data register and sets data-present from the next cycle on. This happens even when data-present is already set, in which case the older byte is overwritten.
- R4: A host read of the input data register clears data-present from the next cycle on. If rx_valid_i is high in that same cycle, the new byte is loaded and data-present stays 1.
- R5: A host write to the input status register sets the input interrupt enable to wdata_i bit 1. Such a write never changes data-present, whatever wdata_i bit 0 holds.
- R6: in_irq_o is high exactly when data-present and the input interrupt enable are both 1.
- R7: A host write to the output data register latches wdata_i on tx_data_o. It pulses tx_start_o for exactly the next cycle and clears output-ready from the next cycle on.
- R8: A tx_ack_i pulse while output-ready is 0 sets output-ready in the next cycle. A pulse while output-ready is 1 has no effect. When a host write to the output data register falls in the same cycle as tx_ack_i, the write takes precedence and output-ready stays 0.
- R9: A host write to the output status register sets the output interrupt enable to wdata_i bit 1 and leaves output-ready unchanged.
- R10: out_irq_o is high exactly when output-ready and the output interrupt enable are both 1.
- R11: A host read of the output data register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host access strobe |
| rnw_i | input | 1 | 1 = read, 0 = write |
| sel_i | input | 2 | Register select |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| tx_start_o | output | 1 | One-cycle strobe to send tx_data_o |
| tx_data_o | output | 8 | Byte to send |
| tx_ack_i | input | 1 | Acknowledge-received pulse |
| in_irq_o | output | 1 | Receive interrupt |
| out_irq_o | output | 1 | Transmit interrupt |

## Verification
The hardest cases to reach are cycles where a link event and a host access collide. One is a byte that arrives in the same cycle the host reads the input data register. The other is an acknowledge that arrives in the same cycle the host writes the output data register. In each case the outcome depends on which action takes precedence. Directed sequences place these pairs in the same cycle. A long stretch of random strobes follows, with every output compared on every cycle against a behavioural model. This also covers masking an interrupt and unmasking it while the event is still pending.

// File: rtl/link_host_pkg.sv
package link_host_pkg;
  typedef enum logic [1:0] {
    SEL_IN_DATA  = 2'd0,
    SEL_OUT_DATA = 2'd1,
    SEL_IN_STAT  = 2'd2,
    SEL_OUT_STAT = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_FLAG_BIT = 0;
  localparam int unsigned STAT_IE_BIT   = 1;
endpackage

// File: rtl/link_rx_side.sv
module link_rx_side #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          take_i,
  input  logic          ie_we_i,
  input  logic          ie_d_i,
  output logic [DW-1:0] data_o,
  output logic          present_o,
  output logic          ie_o,
  output logic          irq_o
);
  logic [DW-1:0] data_q;
  logic          present_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      present_q <= 1'b0;
      ie_q      <= 1'b0;
    end else begin
      if (load_i) data_q <= load_data_i;
      // new arrival wins over a concurrent host read
      if (load_i)      present_q <= 1'b1;
      else if (take_i) present_q <= 1'b0;
      if (ie_we_i) ie_q <= ie_d_i;
    end
  end

  assign data_o    = data_q;
  assign present_o = present_q;
  assign ie_o      = ie_q;
  assign irq_o     = present_q & ie_q;
endmodule

// File: rtl/link_tx_side.sv
module link_tx_side #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ack_i,
  input  logic          ie_we_i,
  input  logic          ie_d_i,
  output logic          tx_start_o,
  output logic [DW-1:0] tx_data_o,
  output logic          ready_o,
  output logic          ie_o,
  output logic          irq_o
);
  logic [DW-1:0] data_q;
  logic          start_q, ready_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      start_q <= 1'b0;
      ready_q <= 1'b1;
      ie_q    <= 1'b0;
    end else begin
      start_q <= wr_i;
      if (wr_i) data_q <= wr_data_i;
      // write wins over a same-cycle ack; ack while ready is a no-op
      if (wr_i)       ready_q <= 1'b0;
      else if (ack_i) ready_q <= 1'b1;
      if (ie_we_i) ie_q <= ie_d_i;
    end
  end

  assign tx_start_o = start_q;
  assign tx_data_o  = data_q;
  assign ready_o    = ready_q;
  assign ie_o       = ie_q;
  assign irq_o      = ready_q & ie_q;
endmodule

// File: rtl/link_host_regs.sv
module link_host_regs
  import link_host_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          rnw_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          tx_start_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ack_i,
  output logic          in_irq_o,
  output logic          out_irq_o
);
  logic          rd, wr;
  reg_sel_e      sel;
  logic [DW-1:0] in_data;
  logic          in_present, in_ie, out_ready, out_ie;

  assign sel = reg_sel_e'(sel_i);
  assign rd  = cs_i & rnw_i;
  assign wr  = cs_i & ~rnw_i;

  function automatic logic [DW-1:0] pack_stat(input logic flag, input logic ie);
    logic [DW-1:0] v;
    v = '0;
    v[STAT_FLAG_BIT] = flag;
    v[STAT_IE_BIT]   = ie;
    return v;
  endfunction

  link_rx_side #(.DW(DW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rx_valid_i),
    .load_data_i(rx_data_i),
    .take_i     (rd && sel == SEL_IN_DATA),
    .ie_we_i    (wr && sel == SEL_IN_STAT),
    .ie_d_i     (wdata_i[STAT_IE_BIT]),
    .data_o     (in_data),
    .present_o  (in_present),
    .ie_o       (in_ie),
    .irq_o      (in_irq_o)
  );

  link_tx_side #(.DW(DW)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && sel == SEL_OUT_DATA),
    .wr_data_i (wdata_i),
    .ack_i     (tx_ack_i),
    .ie_we_i   (wr && sel == SEL_OUT_STAT),
    .ie_d_i    (wdata_i[STAT_IE_BIT]),
    .tx_start_o(tx_start_o),
    .tx_data_o (tx_data_o),
    .ready_o   (out_ready),
    .ie_o      (out_ie),
    .irq_o     (out_irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_IN_DATA:  rdata_o = in_data;
        SEL_OUT_DATA: rdata_o = '0;
        SEL_IN_STAT:  rdata_o = pack_stat(in_present, in_ie);
        SEL_OUT_STAT: rdata_o = pack_stat(out_ready, out_ie);
        default:      rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/link_host_regs_chk.sv
module link_host_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       rnw_i,
  input logic [1:0] sel_i,
  input logic       wd_ie,
  input logic       rx_valid_i,
  input logic       tx_ack_i,
  input logic       tx_start_o,
  input logic       in_irq_o,
  input logic       out_irq_o,
  input logic       in_present,
  input logic       in_ie,
  input logic       out_ready,
  input logic       out_ie
);
  logic rd_in, wr_in_stat, wr_out, wr_out_stat;
  assign rd_in       = cs_i && rnw_i && sel_i == 2'd0;
  assign wr_in_stat  = cs_i && !rnw_i && sel_i == 2'd2;
  assign wr_out      = cs_i && !rnw_i && sel_i == 2'd1;
  assign wr_out_stat = cs_i && !rnw_i && sel_i == 2'd3;

  AST_RX_SETS_PRESENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> in_present); // R3
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_in && !rx_valid_i) |=> !in_present); // R4
  AST_STAT_WR_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_in_stat && !rx_valid_i && !in_present) |=> !in_present); // R5
  AST_IN_IE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_in_stat |=> in_ie == $past(wd_ie)); // R5
  AST_IN_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_irq_o == (in_present && in_ie)); // R6
  AST_TX_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out |=> tx_start_o && !out_ready); // R7
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(wr_out)); // R7
  AST_ACK_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ack_i && !wr_out) |=> out_ready); // R8
  AST_OUT_IE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_out_stat && !wr_out && !tx_ack_i) |=> $stable(out_ready) && out_ie == $past(wd_ie)); // R9
  AST_OUT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_irq_o == (out_ready && out_ie)); // R10
endmodule

bind link_host_regs link_host_regs_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .rnw_i     (rnw_i),
  .sel_i     (sel_i),
  .wd_ie     (wdata_i[1]),
  .rx_valid_i(rx_valid_i),
  .tx_ack_i  (tx_ack_i),
  .tx_start_o(tx_start_o),
  .in_irq_o  (in_irq_o),
  .out_irq_o (out_irq_o),
  .in_present(in_present),
  .in_ie     (in_ie),
  .out_ready (out_ready),
  .out_ie    (out_ie)
);

// File: tb/link_host_regs_bench.sv
`timescale 1ns/1ps
module link_host_regs_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, rnw_i = 1'b0, rx_valid_i = 1'b0, tx_ack_i = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic [7:0] wdata_i = 8'h00, rx_data_i = 8'h00;
  logic [7:0] rdata_o, tx_data_o;
  logic       tx_start_o, in_irq_o, out_irq_o;

  int checks = 0, errors = 0;

  // behavioural reference state
  logic [7:0] m_in_data = 8'h00, m_txd = 8'h00;
  bit m_dp = 0, m_ie = 0, m_rdy = 1, m_oie = 0, m_start = 0;

  always #2.5 clk_i = ~clk_i;

  link_host_regs u_link_host_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rnw_i(rnw_i), .sel_i(sel_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .tx_start_o(tx_start_o), .tx_data_o(tx_data_o), .tx_ack_i(tx_ack_i),
    .in_irq_o(in_irq_o), .out_irq_o(out_irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_in_data = 0; m_txd = 0; m_dp = 0; m_ie = 0; m_rdy = 1; m_oie = 0; m_start = 0;
    end else begin
      bit rd_in, wr;
      rd_in = cs_i && rnw_i && sel_i == 0;
      wr = cs_i && !rnw_i;
      if (rd_in) m_dp = 0;
      if (rx_valid_i) begin m_in_data = rx_data_i; m_dp = 1; end
      if (wr && sel_i == 2) m_ie = wdata_i[1];
      if (wr && sel_i == 3) m_oie = wdata_i[1];
      m_start = wr && sel_i == 1;
      if (m_start) begin m_txd = wdata_i; m_rdy = 0; end
      else if (tx_ack_i) m_rdy = 1;
    end
  end

  function automatic logic [7:0] m_rdata();
    if (!(cs_i && rnw_i)) return 8'h00;
    case (sel_i)
      2'd0: return m_in_data;
      2'd2: return {6'b0, m_ie, m_dp};
      2'd3: return {6'b0, m_oie, m_rdy};
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk_i) begin
    chk("R2 rdata", rdata_o, m_rdata());
    chk("R6 in_irq", {7'b0, in_irq_o}, {7'b0, m_ie && m_dp});
    chk("R10 out_irq", {7'b0, out_irq_o}, {7'b0, m_oie && m_rdy});
    chk("R7 tx_start", {7'b0, tx_start_o}, {7'b0, m_start});
    chk("R7 tx_data", tx_data_o, m_txd);
  end

  task automatic drive(input bit cs, input bit rnw, input logic [1:0] sel, input logic [7:0] wd,
                       input bit rxv, input logic [7:0] rxd, input bit ack);
    @(posedge clk_i); #1;
    cs_i = cs; rnw_i = rnw; sel_i = sel; wdata_i = wd;
    rx_valid_i = rxv; rx_data_i = rxd; tx_ack_i = ack;
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic host_wr(input logic [1:0] sel, input logic [7:0] d); drive(1, 0, sel, d, 0, 0, 0); idle(); endtask
  task automatic host_rd(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    drive(1, 1, sel, 0, 0, 0, 0);
    @(negedge clk_i); #0.1;
    chk(tag, rdata_o, exp);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 tx_start", {7'b0, tx_start_o}, 8'h00);
    chk("R1 irqs", {6'b0, in_irq_o, out_irq_o}, 8'h00);
    host_rd(2, 8'h00, "R1 in status");
    host_rd(3, 8'h01, "R1 out status");
    host_rd(1, 8'h00, "R11 out data read");

    drive(0, 0, 0, 0, 1, 8'h5A, 0); idle();
    host_rd(2, 8'h01, "R3 present set");
    host_wr(2, 8'h02);
    @(negedge clk_i); chk("R6 irq on", {7'b0, in_irq_o}, 8'h01);
    host_wr(2, 8'h01);
    host_rd(2, 8'h01, "R5 ie cleared, present kept");
    @(negedge clk_i); chk("R6 irq masked", {7'b0, in_irq_o}, 8'h00);
    host_wr(2, 8'h02);
    @(negedge clk_i); chk("R6 irq re-raised", {7'b0, in_irq_o}, 8'h01);
    drive(0, 0, 0, 0, 1, 8'hC3, 0); idle();
    host_rd(0, 8'hC3, "R3 overwrite");
    host_rd(2, 8'h02, "R4 present cleared");
    host_wr(2, 8'h03);
    host_rd(2, 8'h02, "R5 bit0 write ignored");
    drive(0, 0, 0, 0, 1, 8'h11, 0);
    drive(1, 1, 0, 0, 1, 8'h22, 0); idle();
    host_rd(2, 8'h03, "R4 arrival wins over read");
    host_rd(0, 8'h22, "R4 new byte kept");

    host_wr(3, 8'h02);
    @(negedge clk_i); chk("R10 out irq on", {7'b0, out_irq_o}, 8'h01);
    host_wr(1, 8'hA7);
    chk("R7 tx byte", tx_data_o, 8'hA7);
    host_rd(3, 8'h02, "R7 ready cleared");
    host_wr(3, 8'h00);
    host_rd(3, 8'h00, "R9 ie write keeps ready");
    host_wr(3, 8'h02);
    drive(0, 0, 0, 0, 0, 0, 1); idle();
    host_rd(3, 8'h03, "R8 ack sets ready");
    drive(0, 0, 0, 0, 0, 0, 1); idle();
    host_rd(3, 8'h03, "R8 spare ack ignored");
    drive(1, 0, 1, 8'h3C, 0, 0, 1); idle();
    host_rd(3, 8'h02, "R8 write beats ack");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive(r[0], r[1], 2'($urandom), 8'($urandom), r[2], 8'($urandom), r[3]);
    end
    idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule